// File: doc/BRIEF.md
# Change-Triggered Multichannel Timestamp Capture

This block watches a parallel word of asynchronous digital lines and logs their activity. Every enabled sample tick takes one snapshot of all lines together, so every channel shares the same time base. It compares the snapshot with the one before it. A record is stored only when at least one line differs. Quiet ticks cost no storage. Each record holds the new line state, a mask of the lines that toggled and the value of a free-running tick counter. Rising and falling edges are both logged, so a consumer can rebuild period and duty cycle for every line.

Records wait in an internal FIFO that is drained through a valid/ready read port. The tick rate is set from outside through a sample-enable strobe, which can be a divided version of the system clock. If the FIFO is full when a change arrives, that change is dropped and a sticky overflow flag is raised. The flag stays set until an explicit clear. A pulse that starts and ends between two ticks is not seen.

Top module: `chg_stamp_capture`

## Requirements
- R1: Each line passes through two synchronizing flops. A change on `din` is first visible to the comparator at the third rising edge after it is applied, provided `sample_en` is high on that edge.
- R2: On an enabled tick, all `CH_W` lines are taken as one word, and `rd_state` of the resulting record is that whole word.
- R3: A tick whose snapshot equals the previous snapshot writes no record.
- R4: `rd_mask` is the bitwise XOR of the previous and new snapshots. A bit is set for a rising edge and for a falling edge, and a record always has at least one mask bit set.
- R5: The first enabled tick after reset only loads the previous-snapshot register and writes no record.
- R6: The timestamp counter is 0 after reset and advances by one on every enabled tick, wrapping modulo 2^`TS_W`. A record carries the counter value of the tick that detected the change, before that tick's increment, so the priming tick has time 0.
- R7: While `sample_en` is low, no snapshot is taken, no record is written and the timestamp holds.
- R8: Records leave in the order they were written. The head is removed on a rising edge with `rd_valid` and `rd_ready` both high, and it stays stable while `rd_ready` is low.
- R9: `fifo_level` equals the number of stored records, with `fifo_full` at `DEPTH` and `fifo_empty` at 0. `rd_valid` equals not empty.
- R10: A change detected while the FIFO is full is discarded, even if a read happens on the same edge, and it sets `ovf_flag` on that edge.
- R11: `ovf_flag` stays set until a `ovf_clear` edge with no simultaneous drop. A drop on the same edge as a clear leaves the flag set.
- R12: After reset, `rd_valid` is 0, `fifo_level` is 0, `fifo_empty` is 1, `fifo_full` is 0 and `ovf_flag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | Sample tick strobe, one clock wide per tick |
| din | input | CH_W | Asynchronous input lines |
| rd_ready | input | 1 | Consumer accepts the head record |
| ovf_clear | input | 1 | Clears the sticky overflow flag |
| rd_valid | output | 1 | A record is available |
| rd_state | output | CH_W | Line state of the head record |
| rd_mask | output | CH_W | Toggled-line mask of the head record |
| rd_time | output | TS_W | Tick timestamp of the head record |
| fifo_level | output | $clog2(DEPTH)+1 | Number of stored records |
| fifo_full | output | 1 | FIFO holds DEPTH records |
| fifo_empty | output | 1 | FIFO holds no record |
| ovf_flag | output | 1 | Sticky flag: a change was dropped |

## Verification
A line change reaches the comparator two edges after it is applied. The record is written on the third edge, so it shows up at the read port just after that edge. Flags, level and the head record all update on the same edge that causes the write, pop or drop. The bench drives inputs on falling edges. It advances a reference model right after each rising edge, using the inputs it applied, and compares every output on the following falling edge. That gives the exact edge count for each result. Directed sequences confirm the two-edge blank window, the priming tick and overflow set/clear at the cycle where each is due.

// File: rtl/chgcap_pkg.sv
package chgcap_pkg;
  localparam int unsigned WORD_MAX = 32;
  typedef logic [WORD_MAX-1:0] word_t;

  // lines that toggled between two snapshots (rising and falling alike)
  function automatic word_t edge_mask(word_t prev_w, word_t cur_w);
    return prev_w ^ cur_w;
  endfunction

  function automatic logic has_change(word_t prev_w, word_t cur_w);
    return |(prev_w ^ cur_w);
  endfunction
endpackage

// File: rtl/chgcap_sync.sv
module chgcap_sync #(
  parameter int unsigned CH_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CH_W-1:0] d_i,
  output logic [CH_W-1:0] q_o
);
  for (genvar g = 0; g < CH_W; g++) begin : g_line
    logic meta_q, safe_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        safe_q <= 1'b0;
      end else begin
        meta_q <= d_i[g];
        safe_q <= meta_q;
      end
    end
    assign q_o[g] = safe_q;
  end
endmodule

// File: rtl/chgcap_detect.sv
module chgcap_detect
  import chgcap_pkg::*;
#(
  parameter int unsigned CH_W = 32,
  parameter int unsigned TS_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_i,
  input  logic [CH_W-1:0] cur_i,
  output logic            chg_o,
  output logic [CH_W-1:0] state_o,
  output logic [CH_W-1:0] mask_o,
  output logic [TS_W-1:0] time_o
);
  logic [CH_W-1:0] prev_q;
  logic            primed_q;
  logic [TS_W-1:0] stamp_q;
  word_t           diff_w;

  assign diff_w  = edge_mask(word_t'(prev_q), word_t'(cur_i));
  assign chg_o   = tick_i & primed_q & has_change(word_t'(prev_q), word_t'(cur_i));
  assign state_o = cur_i;
  assign mask_o  = diff_w[CH_W-1:0];
  assign time_o  = stamp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
      stamp_q  <= '0;
    end else if (tick_i) begin
      prev_q   <= cur_i;
      primed_q <= 1'b1;
      stamp_q  <= stamp_q + 1'b1;
    end
  end
endmodule

// File: rtl/chgcap_fifo.sv
module chgcap_fifo #(
  parameter int unsigned WIDTH = 96,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned CNT_W = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic [CNT_W-1:0] level_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] count_q;
  logic             do_push, do_pop;

  assign full_o    = (count_q == CNT_W'(DEPTH));
  assign empty_o   = (count_q == '0);
  assign do_push   = push_i & ~full_o;
  assign do_pop    = pop_i & ~empty_o;
  assign level_o   = count_q;
  assign rd_data_o = mem_q[rd_ptr_q];

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_ptr_q] <= wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end
endmodule

// File: rtl/chg_stamp_capture.sv
module chg_stamp_capture #(
  parameter int unsigned CH_W  = 32,
  parameter int unsigned TS_W  = 32,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH) + 1,
  localparam int unsigned REC_W = TS_W + 2 * CH_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_en,
  input  logic [CH_W-1:0]  din,
  input  logic             rd_ready,
  input  logic             ovf_clear,
  output logic             rd_valid,
  output logic [CH_W-1:0]  rd_state,
  output logic [CH_W-1:0]  rd_mask,
  output logic [TS_W-1:0]  rd_time,
  output logic [CNT_W-1:0] fifo_level,
  output logic             fifo_full,
  output logic             fifo_empty,
  output logic             ovf_flag
);
  logic [CH_W-1:0]  snap;
  logic             chg_evt;
  logic             drop_evt;
  logic             push_evt;
  logic [CH_W-1:0]  rec_state, rec_mask;
  logic [TS_W-1:0]  rec_time;
  logic [REC_W-1:0] rd_word;
  logic             ovf_q;

  chgcap_sync #(.CH_W(CH_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(din), .q_o(snap)
  );

  chgcap_detect #(.CH_W(CH_W), .TS_W(TS_W)) u_detect (
    .clk(clk), .rst_n(rst_n), .tick_i(sample_en), .cur_i(snap),
    .chg_o(chg_evt), .state_o(rec_state), .mask_o(rec_mask), .time_o(rec_time)
  );

  assign drop_evt = chg_evt & fifo_full;
  assign push_evt = chg_evt & ~fifo_full;

  chgcap_fifo #(.WIDTH(REC_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push_i(push_evt), .wr_data_i({rec_time, rec_mask, rec_state}),
    .pop_i(rd_ready), .rd_data_o(rd_word),
    .level_o(fifo_level), .full_o(fifo_full), .empty_o(fifo_empty)
  );

  assign rd_valid = ~fifo_empty;
  assign rd_state = rd_word[CH_W-1:0];
  assign rd_mask  = rd_word[2*CH_W-1:CH_W];
  assign rd_time  = rd_word[REC_W-1:2*CH_W];

  // drop takes priority over clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ovf_q <= 1'b0;
    else if (drop_evt)  ovf_q <= 1'b1;
    else if (ovf_clear) ovf_q <= 1'b0;
  end
  assign ovf_flag = ovf_q;
endmodule

// File: rtl/chgcap_sva.sv
module chgcap_sva #(
  parameter int unsigned CH_W  = 32,
  parameter int unsigned TS_W  = 32,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sample_en,
  input logic             rd_ready,
  input logic             ovf_clear,
  input logic             rd_valid,
  input logic [CH_W-1:0]  rd_state,
  input logic [CH_W-1:0]  rd_mask,
  input logic [TS_W-1:0]  rd_time,
  input logic [CNT_W-1:0] fifo_level,
  input logic             fifo_full,
  input logic             ovf_flag,
  input logic             chg_evt,
  input logic             drop_evt
);
  assert_record_needs_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    chg_evt |-> sample_en);

  assert_mask_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_mask != '0));

  assert_head_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_state) && $stable(rd_mask) && $stable(rd_time)));

  assert_level_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= CNT_W'(DEPTH));

  assert_full_no_growth_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && !(rd_valid && rd_ready)) |=> (fifo_level == $past(fifo_level)));

  assert_ovf_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> ovf_flag);

  assert_ovf_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clear) |=> ovf_flag);

  assert_ovf_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_clear && !drop_evt) |=> !ovf_flag);
endmodule

bind chg_stamp_capture chgcap_sva #(
  .CH_W(CH_W), .TS_W(TS_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
) u_sva (
  .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .rd_ready(rd_ready),
  .ovf_clear(ovf_clear), .rd_valid(rd_valid), .rd_state(rd_state),
  .rd_mask(rd_mask), .rd_time(rd_time), .fifo_level(fifo_level),
  .fifo_full(fifo_full), .ovf_flag(ovf_flag), .chg_evt(chg_evt),
  .drop_evt(drop_evt)
);

// File: tb/chg_stamp_capture_bench.sv
module chg_stamp_capture_bench;
  localparam int unsigned CH_W  = 20;
  localparam int unsigned TS_W  = 8;
  localparam int unsigned DEPTH = 8;
  localparam int unsigned CNT_W = $clog2(DEPTH) + 1;
  localparam int unsigned REC_W = TS_W + 2 * CH_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_en = 1'b0, rd_ready = 1'b0, ovf_clear = 1'b0;
  logic [CH_W-1:0] din = '0;
  logic rd_valid, fifo_full, fifo_empty, ovf_flag;
  logic [CH_W-1:0] rd_state, rd_mask;
  logic [TS_W-1:0] rd_time;
  logic [CNT_W-1:0] fifo_level;

  always #4 clk = ~clk;

  chg_stamp_capture #(.CH_W(CH_W), .TS_W(TS_W), .DEPTH(DEPTH)) u_chg_stamp_capture (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .din(din),
    .rd_ready(rd_ready), .ovf_clear(ovf_clear), .rd_valid(rd_valid),
    .rd_state(rd_state), .rd_mask(rd_mask), .rd_time(rd_time),
    .fifo_level(fifo_level), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .ovf_flag(ovf_flag)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  logic [CH_W-1:0]  m_s1 = '0, m_s2 = '0, m_prev = '0;
  bit               m_primed = 0, m_ovf = 0;
  logic [TS_W-1:0]  m_ts = '0;
  logic [REC_W-1:0] m_q[$];

  function automatic logic [REC_W-1:0] make_rec(logic [TS_W-1:0] t, logic [CH_W-1:0] p, logic [CH_W-1:0] c);
    return {t, p ^ c, c};
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_step(logic [CH_W-1:0] d, bit en, bit rdy, bit clr);
    bit chg, full, pop;
    pop  = rdy && (m_q.size() > 0);
    full = (m_q.size() == DEPTH);
    chg  = en && m_primed && (m_s2 != m_prev);
    if (chg && full) m_ovf = 1;
    else if (clr)    m_ovf = 0;
    if (pop) void'(m_q.pop_front());
    if (chg && !full) m_q.push_back(make_rec(m_ts, m_prev, m_s2));
    if (en) begin
      m_prev = m_s2; m_primed = 1; m_ts = m_ts + 1'b1;
    end
    m_s2 = m_s1; m_s1 = d;
  endtask

  task automatic compare_all();
    check("R9 level", 64'(fifo_level), 64'(m_q.size()));
    check("R9 full", 64'(fifo_full), 64'(m_q.size() == DEPTH));
    check("R9 empty", 64'(fifo_empty), 64'(m_q.size() == 0));
    check("R8 valid", 64'(rd_valid), 64'(m_q.size() != 0));
    check("R10 ovf", 64'(ovf_flag), 64'(m_ovf));
    if (m_q.size() != 0) begin
      check("R2 state", 64'(rd_state), 64'(m_q[0][CH_W-1:0]));
      check("R4 mask", 64'(rd_mask), 64'(m_q[0][2*CH_W-1:CH_W]));
      check("R6 time", 64'(rd_time), 64'(m_q[0][REC_W-1:2*CH_W]));
    end
  endtask

  // drive at a falling edge, step model after the rising edge, compare at the next falling edge
  task automatic cyc(logic [CH_W-1:0] d, bit en, bit rdy, bit clr);
    din = d; sample_en = en; rd_ready = rdy; ovf_clear = clr;
    @(posedge clk); #1;
    model_step(d, en, rdy, clr);
    @(negedge clk);
    compare_all();
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    logic [CH_W-1:0] d;
    logic [CH_W-1:0] a_val, b_val;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12 valid", 64'(rd_valid), 64'd0);
    check("R12 level", 64'(fifo_level), 64'd0);
    check("R12 empty", 64'(fifo_empty), 64'd1);
    check("R12 full", 64'(fifo_full), 64'd0);
    check("R12 ovf", 64'(ovf_flag), 64'd0);
    rst_n = 1'b1;

    // R5: lines settle with ticks off, first tick primes, no record
    a_val = CH_W'(20'h5A3C1);
    repeat (4) cyc(a_val, 0, 0, 0);
    repeat (6) cyc(a_val, 1, 0, 0);
    check("R5 no record after priming", 64'(fifo_empty), 64'd1);

    // R1: change visible after two sync edges, record on the third
    b_val = a_val ^ CH_W'(20'h80011);
    cyc(b_val, 1, 0, 0);
    check("R1 empty after edge 1", 64'(rd_valid), 64'd0);
    cyc(b_val, 1, 0, 0);
    check("R1 empty after edge 2", 64'(rd_valid), 64'd0);
    cyc(b_val, 1, 0, 0);
    check("R1 valid after edge 3", 64'(rd_valid), 64'd1);
    check("R1 state", 64'(rd_state), 64'(b_val));
    check("R4 rise and fall mask", 64'(rd_mask), 64'(CH_W'(20'h80011)));
    check("R6 time of first change", 64'(rd_time), 64'd8);
    repeat (3) cyc(b_val, 1, 1, 0);

    // R3: unchanged ticks write nothing
    repeat (20) cyc(b_val, 1, 0, 0);
    check("R3 no record on quiet ticks", 64'(fifo_level), 64'd0);

    // R7: changes with ticks off produce nothing
    d = b_val;
    for (int i = 0; i < 10; i++) begin
      d = d ^ CH_W'($urandom);
      cyc(d, 0, 0, 0);
    end
    check("R7 no record without tick", 64'(fifo_level), 64'd0);
    cyc(d, 1, 0, 0);
    check("R7 one record on tick", 64'(fifo_level), 64'd1);

    // R10: fill and overflow with reads held off
    for (int i = 0; i < DEPTH + 4; i++) begin
      d = ~d;
      cyc(d, 1, 0, 0);
    end
    check("R10 full level", 64'(fifo_level), 64'(DEPTH));
    check("R10 ovf set", 64'(ovf_flag), 64'd1);
    // R11: drop in same cycle as clear keeps flag set
    for (int i = 0; i < 4; i++) begin
      d = ~d;
      cyc(d, 1, 0, 1);
    end
    check("R11 drop beats clear", 64'(ovf_flag), 64'd1);
    repeat (4) cyc(d, 1, 0, 1);
    check("R11 clear", 64'(ovf_flag), 64'd0);
    repeat (DEPTH + 2) cyc(d, 1, 1, 0);

    // random phases: varied tick and read rates; R6 wraps with TS_W=8
    for (int seg = 0; seg < 6; seg++) begin
      int en_pct, rd_pct;
      en_pct = 20 + 15 * seg;
      rd_pct = (seg % 2 == 0) ? 80 : 25;
      for (int i = 0; i < 1500; i++) begin
        bit en, rdy, clr;
        if ($urandom_range(0, 2) == 0)
          d = d ^ (CH_W'($urandom) & CH_W'($urandom) & CH_W'($urandom));
        en  = ($urandom_range(0, 99) < en_pct);
        rdy = ($urandom_range(0, 99) < rd_pct);
        clr = ($urandom_range(0, 49) == 0);
        cyc(d, en, rdy, clr);
      end
    end
    finish_run();
  end
endmodule